// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Register Block

This block is a general-purpose I/O peripheral that sits on a plain synchronous register bus. The bus has a two-bit word address, one write strobe, one read strobe and a write data and a read data word. The block drives a vector of pad output levels and a vector of pad output enables. It also samples a vector of pad inputs through a two-stage synchroniser. The number of pins equals the register width.

Build-time parameters choose the software view of the block. The output model is a plain data word, a set/clear pair or a set-only word. There is an optional direction register, which has either an "1 = output" or an "1 = input" meaning. Pins can also be numbered in reversed bit order. A single piece of RTL can therefore match several existing driver conventions. Word offsets are fixed: 0 is the data word, 1 is the set word, 2 is the clear word and 3 is the direction word.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: The register width is 8, 16, 32 or 64, and the pin count equals it. A width outside that list, or enabling both direction register kinds together, stops elaboration.
- R2: After reset all pin outputs are 0. When a direction register exists, all output enables are deasserted. The direction word then reads 0 in "1 = output" mode and all ones in "1 = input" mode.
- R3: In the plain model, a write to offset 0 loads the output levels. Offsets 1 and 2 are unimplemented: they read 0 and writes to them do not change any output.
- R4: In the set/clear model, each 1 bit written to offset 1 drives its pin high and each 1 bit written to offset 2 drives its pin low. Zero bits leave their pins unchanged. Writes to offset 0 are ignored. The new levels show on the pins from the clock edge that samples the write strobe.
- R5: In the set-only model, a write to offset 1 replaces the whole output word, so a 1 drives high and a 0 drives low. Writes to offset 0 are ignored.
- R6: In the set/clear and set-only models, offset 1 reads back the stored output word. Offset 2 always reads 0. Offset 3 reads back the stored direction word when one exists, and reads 0 otherwise.
- R7: With an "1 = output" direction register, a pin's output enable equals its direction bit.
- R8: With an "1 = input" direction register, a pin's output enable is the inverse of its direction bit.
- R9: Without a direction register, every output enable is held asserted and offset 0 reads the synchronised pin inputs.
- R10: With a direction register, offset 0 returns the driven level for output pins and the synchronised input for input pins. Inputs pass through two flops before they can be read.
- R11: In normal order, pin n corresponds to register bit n. In reversed order, pin n corresponds to register bit WIDTH-1-n, for outputs, enables and inputs alike.
- R12: Read data is registered on the edge that samples the read strobe. It is valid from that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Registered read data |
| pin_out | output | WIDTH | Pad output levels |
| pin_oe | output | WIDTH | Pad output enables, 1 = drive |
| pin_in | input | WIDTH | Pad input levels, asynchronous |

## Verification
The bench builds three copies of the block at once.
- An 8-bit copy uses the set/clear model with an "1 = output" direction register and normal order. It exercises accumulate/clear behaviour and the mixed read of driven and sampled bits.
- A 16-bit copy uses the set-only model with an "1 = input" direction register and reversed order. It reaches the inverted enable polarity, the all-ones direction reset and the bit reversal on all three pad vectors, with asymmetric patterns.
- An 8-bit plain-model copy without direction register covers the unimplemented offsets and the bidirectional read path.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [1:0] {
      OUT_PLAIN   = 2'd0,
      OUT_SETCLR  = 2'd1,
      OUT_SETONLY = 2'd2
   } out_model_e;

   localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
   localparam logic [ADDR_W-1:0] OFS_SET  = 2'd1;
   localparam logic [ADDR_W-1:0] OFS_CLR  = 2'd2;
   localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
   parameter int WIDTH   = 32,
   parameter bit REVERSE = 1'b0
) (
   input  logic [WIDTH-1:0] vec_in,
   output logic [WIDTH-1:0] vec_out
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (REVERSE) begin : g_rev
         assign vec_out[b] = vec_in[WIDTH-1-b];
      end else begin : g_fwd
         assign vec_out[b] = vec_in[b];
      end
   end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
   import gpio_ctrl_pkg::*;
#(
   parameter int         WIDTH     = 32,
   parameter out_model_e OUT_MODEL = OUT_SETCLR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  level_q
);
   if (OUT_MODEL == OUT_PLAIN) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        level_q <= '0;
         else if (wr && addr == OFS_DATA)   level_q <= wdata;
      end
   end else if (OUT_MODEL == OUT_SETCLR) begin : g_setclr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= '0;
         end else if (wr) begin
            if (addr == OFS_SET)      level_q <= level_q | wdata;
            else if (addr == OFS_CLR) level_q <= level_q & ~wdata;
         end
      end
   end else begin : g_setonly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      level_q <= '0;
         else if (wr && addr == OFS_SET)  level_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
   import gpio_ctrl_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter bit PRESENT = 1'b1,
   parameter bit INVERT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  enable
);
   localparam logic [WIDTH-1:0] RESET_VAL = INVERT ? '1 : '0;

   if (!PRESENT) begin : g_none
      logic dummy_unused;
      assign dummy_unused = ^{clk, rst_n, wr, addr, wdata};
      assign dir_q  = '0;
      assign enable = '1;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      dir_q <= RESET_VAL;
         else if (wr && addr == OFS_DIR)  dir_q <= wdata;
      end
      if (INVERT) begin : g_inv
         assign enable = ~dir_q;
      end else begin : g_pos
         assign enable = dir_q;
      end
   end
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int         WIDTH       = 32,
   parameter out_model_e OUT_MODEL   = OUT_SETCLR,
   parameter bit         DIR_OUT_REG = 1'b1,
   parameter bit         DIR_IN_REG  = 1'b0,
   parameter bit         PIN_REVERSE = 1'b0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   input  logic [WIDTH-1:0]  pin_in
);
   localparam bit HAS_DIR  = DIR_OUT_REG | DIR_IN_REG;
   localparam bit SET_READ = (OUT_MODEL != OUT_PLAIN);

   // R1: elaboration-time legality checks
   if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
      $error("mmio_gpio_ctrl: WIDTH must be 8, 16, 32 or 64");
   end
   if (DIR_OUT_REG && DIR_IN_REG) begin : g_bad_dir
      $error("mmio_gpio_ctrl: only one direction register kind may be enabled");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mmio_gpio_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] level_r;
   logic [WIDTH-1:0] dir_r;
   logic [WIDTH-1:0] oe_r;
   logic [WIDTH-1:0] pin_in_r;
   logic [WIDTH-1:0] sync_r;
   logic [WIDTH-1:0] data_view;
   logic [WIDTH-1:0] rd_val;

   gpio_out_reg #(.WIDTH(WIDTH), .OUT_MODEL(OUT_MODEL)) u_out (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .level_q(level_r)
   );

   gpio_dir_reg #(.WIDTH(WIDTH), .PRESENT(HAS_DIR), .INVERT(DIR_IN_REG)) u_dir (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .dir_q(dir_r), .enable(oe_r)
   );

   gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(PIN_REVERSE)) u_ord_out (
      .vec_in(level_r), .vec_out(pin_out)
   );
   gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(PIN_REVERSE)) u_ord_oe (
      .vec_in(oe_r), .vec_out(pin_oe)
   );
   gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(PIN_REVERSE)) u_ord_in (
      .vec_in(pin_in), .vec_out(pin_in_r)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in_r), .sync_out(sync_r)
   );

   if (HAS_DIR) begin : g_mix
      assign data_view = (oe_r & level_r) | (~oe_r & sync_r);
   end else begin : g_pins
      assign data_view = sync_r;
   end

   always_comb begin
      unique case (bus_addr)
         OFS_DATA: rd_val = data_view;
         OFS_SET:  rd_val = SET_READ ? level_r : '0;
         OFS_CLR:  rd_val = '0;
         default:  rd_val = dir_r;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
   import gpio_ctrl_pkg::*;
#(
   parameter int         WIDTH     = 32,
   parameter out_model_e OUT_MODEL = OUT_SETCLR,
   parameter bit         HAS_DIR   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe
);
   assert_reset_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0));

   if (HAS_DIR) begin : g_dir
      assert_reset_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (pin_oe == '0));
   end

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   assert_out_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_out));

   assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pin_oe));

   if (OUT_MODEL == OUT_PLAIN) begin : g_plain
      assert_unimpl_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=> $stable(pin_out));
   end else if (OUT_MODEL == OUT_SETCLR) begin : g_setclr
      assert_set_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == OFS_SET) |=>
            ($countones(pin_out) >= $countones($past(pin_out))));
      assert_clr_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == OFS_CLR) |=>
            ($countones(pin_out) <= $countones($past(pin_out))));
      assert_data_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == OFS_DATA) |=> $stable(pin_out));
   end else begin : g_setonly
      assert_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == OFS_DATA) |=> $stable(pin_out));
   end
endmodule

bind mmio_gpio_ctrl gpio_ctrl_chk #(
   .WIDTH(WIDTH), .OUT_MODEL(OUT_MODEL), .HAS_DIR(DIR_OUT_REG | DIR_IN_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_mmio_gpio_ctrl.sv
module test_mmio_gpio_ctrl;
   import gpio_ctrl_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   // unit A: 8-bit set/clear, "1 = output" direction, normal order
   logic [1:0] a_addr = '0;
   logic a_wr = 1'b0, a_rd = 1'b0;
   logic [7:0] a_wdata = '0, a_rdata, a_out, a_oe, a_in = '0;
   // unit B: 16-bit set-only, "1 = input" direction, reversed order
   logic [1:0] b_addr = '0;
   logic b_wr = 1'b0, b_rd = 1'b0;
   logic [15:0] b_wdata = '0, b_rdata, b_out, b_oe, b_in = '0;
   // unit C: 8-bit plain, no direction register
   logic [1:0] c_addr = '0;
   logic c_wr = 1'b0, c_rd = 1'b0;
   logic [7:0] c_wdata = '0, c_rdata, c_out, c_oe, c_in = '0;

   mmio_gpio_ctrl #(.WIDTH(8), .OUT_MODEL(OUT_SETCLR), .DIR_OUT_REG(1'b1),
                    .DIR_IN_REG(1'b0), .PIN_REVERSE(1'b0)) i_mmio_gpio_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr), .bus_rd(a_rd),
      .bus_wdata(a_wdata), .bus_rdata(a_rdata), .pin_out(a_out), .pin_oe(a_oe),
      .pin_in(a_in));

   mmio_gpio_ctrl #(.WIDTH(16), .OUT_MODEL(OUT_SETONLY), .DIR_OUT_REG(1'b0),
                    .DIR_IN_REG(1'b1), .PIN_REVERSE(1'b1)) i_mmio_gpio_ctrl_b (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
      .bus_wdata(b_wdata), .bus_rdata(b_rdata), .pin_out(b_out), .pin_oe(b_oe),
      .pin_in(b_in));

   mmio_gpio_ctrl #(.WIDTH(8), .OUT_MODEL(OUT_PLAIN), .DIR_OUT_REG(1'b0),
                    .DIR_IN_REG(1'b0), .PIN_REVERSE(1'b0)) i_mmio_gpio_ctrl_c (
      .clk(clk), .rst_n(rst_n), .bus_addr(c_addr), .bus_wr(c_wr), .bus_rd(c_rd),
      .bus_wdata(c_wdata), .bus_rdata(c_rdata), .pin_out(c_out), .pin_oe(c_oe),
      .pin_in(c_in));

   typedef struct {
      int          unit;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t sb_q[$];
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic rd_pend = 1'b0;

   task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input int unit, input logic [1:0] addr, input logic [15:0] d);
      @(negedge clk);
      case (unit)
         0: begin a_addr = addr; a_wdata = d[7:0]; a_wr = 1'b1; end
         1: begin b_addr = addr; b_wdata = d;      b_wr = 1'b1; end
         default: begin c_addr = addr; c_wdata = d[7:0]; c_wr = 1'b1; end
      endcase
      @(negedge clk);
      a_wr = 1'b0; b_wr = 1'b0; c_wr = 1'b0;
   endtask

   // driver: queue the expected word, then issue the read strobe
   task automatic bus_read(input int unit, input logic [1:0] addr,
                           input logic [15:0] exp, input string tag);
      rd_item_t it;
      it.unit = unit; it.exp = exp; it.tag = tag;
      @(negedge clk);
      sb_q.push_back(it);
      case (unit)
         0: begin a_addr = addr; a_rd = 1'b1; end
         1: begin b_addr = addr; b_rd = 1'b1; end
         default: begin c_addr = addr; c_rd = 1'b1; end
      endcase
      @(negedge clk);
      a_rd = 1'b0; b_rd = 1'b0; c_rd = 1'b0;
   endtask

   // monitor: data captured at the strobe edge is compared at the next falling edge
   always @(posedge clk) rd_pend <= a_rd | b_rd | c_rd;

   always @(negedge clk) begin
      if (rd_pend) begin
         if (sb_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R12: read data with no queued expectation, got %h expected none", a_rdata);
         end else begin
            rd_item_t it;
            logic [15:0] got;
            it = sb_q.pop_front();
            case (it.unit)
               0: got = {8'h00, a_rdata};
               1: got = b_rdata;
               default: got = {8'h00, c_rdata};
            endcase
            check(got, it.exp, it.tag);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: pin count equals the register width
      check(16'($bits(b_out)), 16'd16, "R1 pin count of 16-bit unit");

      // R2: reset state
      check({8'h00, a_out}, 16'h0000, "R2 unit A outputs after reset");
      check({8'h00, a_oe},  16'h0000, "R2 unit A enables after reset");
      check(b_out, 16'h0000, "R2 unit B outputs after reset");
      check(b_oe,  16'h0000, "R2 unit B enables after reset");
      bus_read(0, OFS_DIR, 16'h0000, "R2 unit A direction reset value");
      bus_read(1, OFS_DIR, 16'hFFFF, "R2 unit B inverted direction reset value");
      check({8'h00, c_oe}, 16'h00FF, "R9 unit C enables held asserted");

      // R7: "1 = output" direction
      bus_write(0, OFS_DIR, 16'h00FF);
      check({8'h00, a_oe}, 16'h00FF, "R7 enables follow direction bits");

      // R4: set/clear accumulate
      bus_write(0, OFS_SET, 16'h000F);
      check({8'h00, a_out}, 16'h000F, "R4 first set");
      bus_write(0, OFS_SET, 16'h0030);
      check({8'h00, a_out}, 16'h003F, "R4 set keeps earlier ones");
      bus_write(0, OFS_CLR, 16'h0003);
      check({8'h00, a_out}, 16'h003C, "R4 clear drops only its bits");
      bus_write(0, OFS_DATA, 16'h00FF);
      check({8'h00, a_out}, 16'h003C, "R4 data write ignored");

      // R6: readback
      bus_read(0, OFS_SET, 16'h003C, "R6 set word reads stored levels");
      bus_read(0, OFS_CLR, 16'h0000, "R6 clear word reads zero");

      // R10: mixed read
      bus_write(0, OFS_DIR, 16'h00F0);
      check({8'h00, a_oe}, 16'h00F0, "R7 partial direction");
      a_in = 8'hA5;
      repeat (3) @(negedge clk);
      bus_read(0, OFS_DATA, 16'h0035, "R10 driven high nibble, sampled low nibble");
      bus_read(0, OFS_DIR, 16'h00F0, "R6 direction readback");

      // R12: read data holds without a strobe
      repeat (4) @(negedge clk);
      check({8'h00, a_rdata}, 16'h00F0, "R12 read data held");

      // R8, R11, R5: unit B
      bus_write(1, OFS_DIR, 16'h0000);
      check(b_oe, 16'hFFFF, "R8 zero direction bits enable drivers");
      bus_write(1, OFS_SET, 16'h0003);
      check(b_out, 16'hC000, "R11 reversed order on outputs");
      bus_write(1, OFS_SET, 16'h0100);
      check(b_out, 16'h0080, "R5 set word replaces all levels");
      bus_write(1, OFS_DATA, 16'hFFFF);
      check(b_out, 16'h0080, "R5 data write ignored");
      bus_read(1, OFS_SET, 16'h0100, "R6 set-only word readback");
      bus_write(1, OFS_DIR, 16'h00FF);
      check(b_oe, 16'h00FF, "R11 reversed order on enables");
      b_in = 16'h3000;
      repeat (3) @(negedge clk);
      bus_read(1, OFS_DATA, 16'h010C, "R11 R10 reversed inputs mixed with outputs");

      // R3, R9: unit C
      bus_write(2, OFS_DATA, 16'h005A);
      check({8'h00, c_out}, 16'h005A, "R3 plain data write");
      bus_write(2, OFS_SET, 16'h00FF);
      check({8'h00, c_out}, 16'h005A, "R3 unimplemented set offset ignored");
      bus_write(2, OFS_CLR, 16'h00FF);
      check({8'h00, c_out}, 16'h005A, "R3 unimplemented clear offset ignored");
      bus_read(2, OFS_SET, 16'h0000, "R3 unimplemented offset reads zero");
      bus_read(2, OFS_DIR, 16'h0000, "R6 absent direction reads zero");
      c_in = 8'hC3;
      repeat (3) @(negedge clk);
      bus_read(2, OFS_DATA, 16'h00C3, "R9 bidirectional read returns pins");

      repeat (2) @(negedge clk);
      if (sb_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R12: %0d reads outstanding, expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule